// File: doc/BRIEF.md
# Equalizer sleep, mute and bypass controller

This block decides, every clock cycle, which operating state the equalizer datapath is in: powered down, muted, bypassed or active. It takes a sleep-mode code, a mute request and a bypass request, either from three device pins or from fields of the register interface, together with a carrier-present flag from the signal detector. From these it drives a power-down strobe, a mute flag, a bypass flag and a registered parallel data output. The data output carries zeros while the path sleeps or is muted, the unequalized lanes while bypassed, and the equalized lanes otherwise.

Automatic sleep powers the datapath down only after the carrier has stayed absent for a programmable number of clock cycles. The default of 20000 cycles gives 200 µs at 100 MHz. A carrier that returns during that countdown cancels it, and a carrier that returns while asleep wakes the path two clock edges later. An optional link lets carrier loss act as a mute request, so the output goes silent as soon as the signal disappears.

Top module: `eq_sleep_mute_ctrl`

## Requirements
- R1: While `rst` is sampled high, and after it is released until new inputs take effect, `pwr_down`, `out_muted`, `bypass_en` and `data_out` are all 0.
- R2: Sleep code 2'b10 (forced) drives `pwr_down` high on the second rising edge after it is applied, whatever the carrier does. Codes 2'b00 (off) and 2'b11 (reserved, treated as off) never power the path down; leaving the forced code under them clears `pwr_down` two edges later.
- R3: With sleep code 2'b01 (auto), `pwr_down` rises exactly PD_CYCLES+1 rising edges after `carrier_ok` is first sampled low, provided the carrier stays low.
- R4: In auto mode, a carrier sampled high before the countdown completes cancels it. A later loss restarts the full PD_CYCLES+1 edge delay.
- R5: In auto mode, `pwr_down` falls on the second rising edge after `carrier_ok` is sampled high, and not on the first.
- R6: Priority is sleep over mute over bypass. At most one of `pwr_down`, `out_muted` and `bypass_en` is high, and each is registered one edge after the inputs that select it.
- R7: `data_out` is 0 while powered down or muted, equals the `raw_data` sampled on the previous edge while bypassed, and equals the `eq_data` sampled on the previous edge otherwise.
- R8: With `cd_to_mute` high, a carrier sampled low acts as a mute request, unless sleep has priority.
- R9: With `cfg_from_reg` high, the register fields `reg_sleep_code`, `reg_mute` and `reg_bypass` are used and the pins are ignored. With it low, the pins are used: `pin_auto_sleep` high selects auto (2'b01) and low selects off (2'b00), and the register fields are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_from_reg | input | 1 | 1: use register fields, 0: use pins |
| pin_auto_sleep | input | 1 | Pin control: 1 auto sleep, 0 sleep off |
| pin_mute | input | 1 | Pin control: mute request |
| pin_bypass | input | 1 | Pin control: bypass request |
| reg_sleep_code | input | 2 | Register sleep code: 00 off, 01 auto, 10 forced, 11 reserved (as 00) |
| reg_mute | input | 1 | Register mute request |
| reg_bypass | input | 1 | Register bypass request |
| carrier_ok | input | 1 | 1 while an input signal is detected |
| cd_to_mute | input | 1 | 1: carrier loss also requests mute |
| eq_data | input | DATA_W | Equalized datapath lanes |
| raw_data | input | DATA_W | Unequalized (bypass) lanes |
| pwr_down | output | 1 | Datapath powered down |
| out_muted | output | 1 | Output muted (data forced to 0) |
| bypass_en | output | 1 | Equalizer bypassed |
| data_out | output | DATA_W | Registered output lanes |

## Verification
On every cycle the checker enforces the following: the three state flags are mutually exclusive, the data is zero while sleeping or muted, the data tracks the selected path one edge late, and carrier loss mutes when linked. It also holds that the path stays awake with the sleep code off or with the carrier present, that a held forced code powers it down, and that any power-down edge is preceded either by the forced code or by a full run of PD_CYCLES carrier-absent cycles. Only the bench's scenarios can show a countdown cancelled part-way and restarted, the exact edge on which the path wakes, and whether the pins or the register fields are the ones in control. The bench also sweeps every combination of source, codes, requests, link and carrier against an arithmetic model.

// File: rtl/eq_sleep_mute_pkg.sv
package eq_sleep_mute_pkg;

  typedef enum logic [1:0] {
    SLP_OFF   = 2'b00,
    SLP_AUTO  = 2'b01,
    SLP_FORCE = 2'b10,
    SLP_RSVD  = 2'b11
  } sleep_code_e;

  typedef enum logic [1:0] {
    OP_ACTIVE = 2'd0,
    OP_BYPASS = 2'd1,
    OP_MUTE   = 2'd2,
    OP_SLEEP  = 2'd3
  } op_state_e;

  typedef struct packed {
    sleep_code_e code;
    logic        mute;
    logic        bypass;
  } ctrl_t;

  function automatic sleep_code_e map_code(input logic [1:0] raw);
    sleep_code_e c;
    c = sleep_code_e'(raw);
    if (c == SLP_RSVD) c = SLP_OFF;
    return c;
  endfunction

endpackage

// File: rtl/eq_ctrl_select.sv
module eq_ctrl_select
  import eq_sleep_mute_pkg::*;
(
  input  logic       cfg_from_reg,
  input  logic       pin_auto_sleep,
  input  logic       pin_mute,
  input  logic       pin_bypass,
  input  logic [1:0] reg_sleep_code,
  input  logic       reg_mute,
  input  logic       reg_bypass,
  input  logic       carrier_ok,
  input  logic       cd_to_mute,
  output ctrl_t      ctrl
);

  logic carrier_mute;

  assign carrier_mute = cd_to_mute & ~carrier_ok;

  always_comb begin
    if (cfg_from_reg) begin
      ctrl.code   = map_code(reg_sleep_code);
      ctrl.mute   = reg_mute | carrier_mute;
      ctrl.bypass = reg_bypass;
    end else begin
      ctrl.code   = pin_auto_sleep ? SLP_AUTO : SLP_OFF;
      ctrl.mute   = pin_mute | carrier_mute;
      ctrl.bypass = pin_bypass;
    end
  end

endmodule

// File: rtl/eq_sleep_timer.sv
module eq_sleep_timer
  import eq_sleep_mute_pkg::*;
#(
  parameter int PD_CYCLES = 20000
) (
  input  logic        clk,
  input  logic        rst,
  input  sleep_code_e code,
  input  logic        carrier_ok,
  output logic        asleep
);

  localparam int CNT_W = (PD_CYCLES < 2) ? 1 : $clog2(PD_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             asleep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      asleep_q <= 1'b0;
    end else begin
      unique case (code)
        SLP_FORCE: begin
          asleep_q <= 1'b1;
          cnt_q    <= '0;
        end
        SLP_AUTO: begin
          if (carrier_ok) begin
            asleep_q <= 1'b0;
            cnt_q    <= '0;
          end else if (!asleep_q) begin
            if (cnt_q == LAST) begin
              asleep_q <= 1'b1;
              cnt_q    <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: begin
          asleep_q <= 1'b0;
          cnt_q    <= '0;
        end
      endcase
    end
  end

  assign asleep = asleep_q;

endmodule

// File: rtl/eq_out_stage.sv
module eq_out_stage
  import eq_sleep_mute_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              asleep,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] eq_data,
  input  logic [DATA_W-1:0] raw_data,
  output logic              pwr_down,
  output logic              out_muted,
  output logic              bypass_en,
  output logic [DATA_W-1:0] data_out
);

  op_state_e         st;
  logic [DATA_W-1:0] lane_nxt;

  always_comb begin
    if (asleep)           st = OP_SLEEP;
    else if (ctrl.mute)   st = OP_MUTE;
    else if (ctrl.bypass) st = OP_BYPASS;
    else                  st = OP_ACTIVE;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    always_comb begin
      unique case (st)
        OP_ACTIVE: lane_nxt[i] = eq_data[i];
        OP_BYPASS: lane_nxt[i] = raw_data[i];
        default:   lane_nxt[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_down  <= 1'b0;
      out_muted <= 1'b0;
      bypass_en <= 1'b0;
      data_out  <= '0;
    end else begin
      pwr_down  <= (st == OP_SLEEP);
      out_muted <= (st == OP_MUTE);
      bypass_en <= (st == OP_BYPASS);
      data_out  <= lane_nxt;
    end
  end

endmodule

// File: rtl/eq_sleep_mute_ctrl.sv
module eq_sleep_mute_ctrl
  import eq_sleep_mute_pkg::*;
#(
  parameter int DATA_W    = 4,
  parameter int PD_CYCLES = 20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_from_reg,
  input  logic              pin_auto_sleep,
  input  logic              pin_mute,
  input  logic              pin_bypass,
  input  logic [1:0]        reg_sleep_code,
  input  logic              reg_mute,
  input  logic              reg_bypass,
  input  logic              carrier_ok,
  input  logic              cd_to_mute,
  input  logic [DATA_W-1:0] eq_data,
  input  logic [DATA_W-1:0] raw_data,
  output logic              pwr_down,
  output logic              out_muted,
  output logic              bypass_en,
  output logic [DATA_W-1:0] data_out
);

  ctrl_t ctrl;
  logic  asleep;

  eq_ctrl_select u_sel (
    .cfg_from_reg   (cfg_from_reg),
    .pin_auto_sleep (pin_auto_sleep),
    .pin_mute       (pin_mute),
    .pin_bypass     (pin_bypass),
    .reg_sleep_code (reg_sleep_code),
    .reg_mute       (reg_mute),
    .reg_bypass     (reg_bypass),
    .carrier_ok     (carrier_ok),
    .cd_to_mute     (cd_to_mute),
    .ctrl           (ctrl)
  );

  eq_sleep_timer #(.PD_CYCLES(PD_CYCLES)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .code       (ctrl.code),
    .carrier_ok (carrier_ok),
    .asleep     (asleep)
  );

  eq_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .asleep    (asleep),
    .ctrl      (ctrl),
    .eq_data   (eq_data),
    .raw_data  (raw_data),
    .pwr_down  (pwr_down),
    .out_muted (out_muted),
    .bypass_en (bypass_en),
    .data_out  (data_out)
  );

endmodule

// File: rtl/eq_sleep_mute_ctrl_chk.sv
module eq_sleep_mute_ctrl_chk #(
  parameter int DATA_W    = 4,
  parameter int PD_CYCLES = 20000
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_from_reg,
  input logic              pin_auto_sleep,
  input logic [1:0]        reg_sleep_code,
  input logic              carrier_ok,
  input logic              cd_to_mute,
  input logic [DATA_W-1:0] eq_data,
  input logic [DATA_W-1:0] raw_data,
  input logic              pwr_down,
  input logic              out_muted,
  input logic              bypass_en,
  input logic [DATA_W-1:0] data_out
);

  localparam int RUN_W = $clog2(PD_CYCLES + 1);

  logic [1:0] code_c;
  logic       forced_c, off_c, auto_c;
  logic [RUN_W-1:0] lowrun;
  logic [1:0] age;

  always_comb begin
    if (cfg_from_reg) code_c = (reg_sleep_code == 2'b11) ? 2'b00 : reg_sleep_code;
    else              code_c = {1'b0, pin_auto_sleep};
  end
  assign forced_c = (code_c == 2'b10);
  assign off_c    = (code_c == 2'b00);
  assign auto_c   = (code_c == 2'b01);

  always_ff @(posedge clk) begin
    if (rst) begin
      lowrun <= '0;
      age    <= '0;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      if (auto_c && !carrier_ok) begin
        if (lowrun != RUN_W'(PD_CYCLES)) lowrun <= lowrun + 1'b1;
      end else begin
        lowrun <= '0;
      end
    end
  end

  // R6: sleep, mute and bypass flags are exclusive
  assert_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> $onehot0({pwr_down, out_muted, bypass_en}));

  // R7: zero data while asleep or muted
  assert_zero_when_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) && (pwr_down || out_muted) |-> (data_out == '0));

  // R7: active data follows equalized lanes one edge late
  assert_active_data_R7: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) && !pwr_down && !out_muted && !bypass_en |-> (data_out == $past(eq_data)));

  // R7: bypass data follows raw lanes one edge late
  assert_bypass_data_R7: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) && bypass_en |-> (data_out == $past(raw_data)));

  // R8: carrier loss with link mutes unless asleep
  assert_link_mute_R8: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) && $past(cd_to_mute && !carrier_ok) && !pwr_down |-> out_muted);

  // R2: a held forced code powers down
  assert_force_sleep_R2: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) && $past(forced_c) && $past(forced_c, 2) |-> pwr_down);

  // R2: a held off code keeps the path awake
  assert_off_awake_R2: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) && $past(off_c) && $past(off_c, 2) |-> !pwr_down);

  // R5: carrier present in auto mode keeps the path awake
  assert_wake_R5: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) && $past(auto_c && carrier_ok) && $past(auto_c && carrier_ok, 2) |-> !pwr_down);

  // R3: every power-down follows a forced code or a full carrier-absent run
  assert_delay_R3: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) && $rose(pwr_down) |-> ($past(lowrun) == RUN_W'(PD_CYCLES)) || $past(forced_c, 2));

endmodule

bind eq_sleep_mute_ctrl eq_sleep_mute_ctrl_chk #(.DATA_W(DATA_W), .PD_CYCLES(PD_CYCLES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_from_reg   (cfg_from_reg),
  .pin_auto_sleep (pin_auto_sleep),
  .reg_sleep_code (reg_sleep_code),
  .carrier_ok     (carrier_ok),
  .cd_to_mute     (cd_to_mute),
  .eq_data        (eq_data),
  .raw_data       (raw_data),
  .pwr_down       (pwr_down),
  .out_muted      (out_muted),
  .bypass_en      (bypass_en),
  .data_out       (data_out)
);

// File: tb/eq_sleep_mute_ctrl_test.sv
module eq_sleep_mute_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW  = 4;
  localparam int PD  = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_from_reg, pin_auto_sleep, pin_mute, pin_bypass;
  logic [1:0]    reg_sleep_code;
  logic          reg_mute, reg_bypass, carrier_ok, cd_to_mute;
  logic [DW-1:0] eq_data, raw_data;
  logic          pwr_down, out_muted, bypass_en;
  logic [DW-1:0] data_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  bit model_on = 1'b0;

  // reference model state
  logic          m_asleep;
  int            m_cnt;
  logic          e_pd, e_mu, e_by;
  logic [DW-1:0] e_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  eq_sleep_mute_ctrl #(.DATA_W(DW), .PD_CYCLES(PD)) uut (
    .clk(clk), .rst(rst), .cfg_from_reg(cfg_from_reg), .pin_auto_sleep(pin_auto_sleep),
    .pin_mute(pin_mute), .pin_bypass(pin_bypass), .reg_sleep_code(reg_sleep_code),
    .reg_mute(reg_mute), .reg_bypass(reg_bypass), .carrier_ok(carrier_ok),
    .cd_to_mute(cd_to_mute), .eq_data(eq_data), .raw_data(raw_data),
    .pwr_down(pwr_down), .out_muted(out_muted), .bypass_en(bypass_en), .data_out(data_out)
  );

  always @(posedge clk) begin
    int  code;
    bit  mu, by;
    if (rst) begin
      m_asleep <= 1'b0; m_cnt <= 0;
      e_pd <= 1'b0; e_mu <= 1'b0; e_by <= 1'b0; e_d <= '0;
    end else begin
      if (cfg_from_reg) begin
        code = (reg_sleep_code == 2'b11) ? 0 : int'(reg_sleep_code);
        mu = reg_mute; by = reg_bypass;
      end else begin
        code = pin_auto_sleep ? 1 : 0;
        mu = pin_mute; by = pin_bypass;
      end
      if (cd_to_mute && !carrier_ok) mu = 1'b1;
      e_pd <= m_asleep;
      e_mu <= !m_asleep && mu;
      e_by <= !m_asleep && !mu && by;
      e_d  <= (m_asleep || mu) ? '0 : (by ? raw_data : eq_data);
      if (code == 2) begin
        m_asleep <= 1'b1; m_cnt <= 0;
      end else if (code == 1) begin
        if (carrier_ok) begin
          m_asleep <= 1'b0; m_cnt <= 0;
        end else if (!m_asleep) begin
          if (m_cnt == PD - 1) begin m_asleep <= 1'b1; m_cnt <= 0; end
          else m_cnt <= m_cnt + 1;
        end
      end else begin
        m_asleep <= 1'b0; m_cnt <= 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_compare();
    check(pwr_down  == e_pd, "R3 model pwr_down",  int'(pwr_down),  int'(e_pd));
    check(out_muted == e_mu, "R6 model out_muted", int'(out_muted), int'(e_mu));
    check(bypass_en == e_by, "R6 model bypass_en", int'(bypass_en), int'(e_by));
    check(data_out  == e_d,  "R7 model data_out",  int'(data_out),  int'(e_d));
  endtask

  // advance one cycle: ends at a falling edge, compares against the model
  task automatic step();
    @(negedge clk);
    if (model_on) model_compare();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rst = 1'b1;
    cfg_from_reg = 1'b1; pin_auto_sleep = 1'b0; pin_mute = 1'b0; pin_bypass = 1'b0;
    reg_sleep_code = 2'b00; reg_mute = 1'b0; reg_bypass = 1'b0;
    carrier_ok = 1'b1; cd_to_mute = 1'b0; eq_data = 4'h5; raw_data = 4'hA;
    repeat (3) step();
    // R1: reset state
    check({pwr_down, out_muted, bypass_en} == 3'b000, "R1 flags in reset", int'({pwr_down, out_muted, bypass_en}), 0);
    check(data_out == '0, "R1 data in reset", int'(data_out), 0);
    rst = 1'b0;
    step();
    check(pwr_down == 1'b0, "R1 pwr_down after release", int'(pwr_down), 0);
    model_on = 1'b1;

    // R2: forced sleep, carrier present
    reg_sleep_code = 2'b10;
    step();
    check(pwr_down == 1'b0, "R2 forced not yet after 1 edge", int'(pwr_down), 0);
    step();
    check(pwr_down == 1'b1, "R2 forced after 2 edges", int'(pwr_down), 1);
    check(data_out == '0, "R7 data zero while asleep", int'(data_out), 0);
    // R6: sleep beats mute and bypass
    reg_mute = 1'b1; reg_bypass = 1'b1;
    step();
    check({pwr_down, out_muted, bypass_en} == 3'b100, "R6 sleep over mute and bypass", int'({pwr_down, out_muted, bypass_en}), 4);
    // R2: reserved code wakes like off
    reg_sleep_code = 2'b11;
    step(); step();
    check(pwr_down == 1'b0, "R2 reserved code awake", int'(pwr_down), 0);
    check(out_muted == 1'b1 && bypass_en == 1'b0, "R6 mute over bypass", int'({out_muted, bypass_en}), 2);
    reg_mute = 1'b0;
    step();
    check(bypass_en == 1'b1 && data_out == 4'hA, "R7 bypass passes raw lanes", int'(data_out), 10);
    reg_bypass = 1'b0;
    carrier_ok = 1'b0;
    repeat (20) step();
    check(pwr_down == 1'b0, "R2 reserved code never sleeps without carrier", int'(pwr_down), 0);
    check(data_out == 4'h5, "R7 active passes equalized lanes", int'(data_out), 5);

    // R3: automatic delay
    carrier_ok = 1'b1; reg_sleep_code = 2'b01;
    repeat (3) step();
    carrier_ok = 1'b0;
    begin
      int k = 0;
      while (!pwr_down && k < 50) begin step(); k++; end
      check(k == PD + 1, "R3 edges to power-down", k, PD + 1);
    end

    // R5: wake timing
    carrier_ok = 1'b1;
    step();
    check(pwr_down == 1'b1, "R5 still down after 1 edge", int'(pwr_down), 1);
    step();
    check(pwr_down == 1'b0, "R5 awake after 2 edges", int'(pwr_down), 0);

    // R4: cancel and restart
    carrier_ok = 1'b0;
    repeat (PD - 1) step();
    carrier_ok = 1'b1;
    step();
    carrier_ok = 1'b0;
    begin
      int k = 0;
      while (!pwr_down && k < 50) begin step(); k++; end
      check(k == PD + 1, "R4 restarted countdown length", k, PD + 1);
    end
    carrier_ok = 1'b1;
    step(); step();

    // R8: carrier loss mutes via link
    reg_sleep_code = 2'b00; cd_to_mute = 1'b1; carrier_ok = 1'b0;
    step();
    check(out_muted == 1'b1 && data_out == '0, "R8 link mutes on carrier loss", int'({out_muted, data_out}), 16);
    cd_to_mute = 1'b0;
    step();
    check(out_muted == 1'b0, "R8 no mute without link", int'(out_muted), 0);
    carrier_ok = 1'b1;

    // R9: pins in control, register fields ignored
    cfg_from_reg = 1'b0; pin_auto_sleep = 1'b0; reg_sleep_code = 2'b10; reg_mute = 1'b1;
    repeat (4) step();
    check(pwr_down == 1'b0 && out_muted == 1'b0, "R9 register fields ignored in pin mode", int'({pwr_down, out_muted}), 0);
    pin_auto_sleep = 1'b1; carrier_ok = 1'b0;
    repeat (PD + 1) step();
    check(pwr_down == 1'b1, "R9 pin selects auto sleep", int'(pwr_down), 1);
    pin_mute = 1'b1; carrier_ok = 1'b1;
    step(); step();
    check(out_muted == 1'b1, "R9 pin mute in pin mode", int'(out_muted), 1);
    cfg_from_reg = 1'b1; reg_mute = 1'b0; reg_sleep_code = 2'b00;
    step();
    check(out_muted == 1'b0, "R9 pin mute ignored in register mode", int'(out_muted), 0);

    // sweep all control combinations against the model
    for (int idx = 0; idx < 256; idx++) begin
      cfg_from_reg   = idx[0];
      reg_sleep_code = idx[2:1];
      pin_auto_sleep = idx[1];
      reg_mute       = idx[3];
      pin_mute       = idx[3];
      reg_bypass     = idx[4];
      pin_bypass     = ~idx[4];
      cd_to_mute     = idx[5];
      carrier_ok     = idx[6] ^ idx[7];
      for (int c = 0; c < ((idx % 5 == 0) ? 12 : 3); c++) begin
        eq_data  = DW'(idx + c);
        raw_data = DW'(idx * 3 + c * 7);
        step();
      end
    end
    repeat (2) step();
    finish_run();
  end

endmodule